// File: doc/BRIEF.md
# MDIO Management Station

This block is the management-side master for a clause-22 MDIO link to an Ethernet PHY. Software first places the write value in a 16-bit data register. It then writes a 14-bit control word that holds the PHY address, the register address, a divider select, a write flag and a busy flag. Writing that word with busy set launches a 64-bit frame. The block generates MDC from the system clock and shifts the frame out on MDIO. Hardware clears busy when the last bit has been clocked. The busy flag is therefore both the start command and the completion status.

On a read, the station drives the line up to the turnaround and then releases it. It samples the PHY's 16 data bits on MDC rising edges. When busy drops, the sampled value appears in the data register. Software must poll busy at 0 before it starts the next transaction. The PHY integrated on the same die responds at PHY address 0.

Top module: `mdio_station`

## Requirements
- R1: After reset, busy, mdc, mdio_oe, data_q and ctrl_q are all 0.
- R2: The control word layout is busy bit 0, write flag bit 1, divider select bits 3:2, register address bits 8:4 and PHY address bits 13:9. Writing it (reg_addr=1) while idle stores it. busy reads 1 from the next cycle until the frame ends and then reads 0. A word written with busy=0 is stored and starts no frame.
- R3: A write frame puts 64 bits on mdio_o in this order, one per MDC period, MSB first: 32 ones, start 01, opcode 01, PHY address, register address, turnaround 10, then the 16 data bits. mdio_oe is high for all 64 bits.
- R4: A read frame drives 32 ones, start 01, opcode 10, PHY address and register address, with mdio_oe high for those 46 bits. mdio_oe is low for the turnaround and the 16 data bits.
- R5: During a read, mdio_i is sampled on the MDC rising edges of bits 48 to 63, MSB first. The result is in data_q when busy reads 0.
- R6: The MDC period is 2×HALFn system clocks, where n is the divider select (defaults 10, 13, 21, 31). MDC is low whenever busy is 0.
- R7: mdio_o and mdio_oe change only when MDC falls or while MDC is low. They are stable while MDC is high.
- R8: Register writes to either register while busy is 1 are ignored. The frame in progress, ctrl_q and data_q are unchanged.
- R9: A data register write (reg_addr=0) while idle reads back on data_q. After a write frame, data_q still holds the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the data register, 1 selects the control word |
| reg_wdata | input | 16 | Write value (the control word uses bits 13:0) |
| data_q | output | 16 | Data register contents |
| ctrl_q | output | 14 | Control word contents, with live busy at bit 0 |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO pad input |
| mdio_o | output | 1 | MDIO pad output value |
| mdio_oe | output | 1 | MDIO pad output enable |

## Verification
A table of writes and reads runs through the frame path. The entries mix PHY addresses 0 and 31, register addresses 0 and 31, all four divider selects and data words of all zeros, all ones and alternating bits. Opcode, address or bit-order faults therefore show up in the 64 captured bits and the enable mask. The read return values 0x8001 and 0x2000 tell an MSB-first capture from a reversed one and from an off-by-one sample. The measured MDC period for each select tells the divisors apart. A write burst issued in the middle of a frame separates an ignored write from one that leaks into the frame or the registers. A control word written without busy shows that storing a word and launching a frame are distinct actions.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(46);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(48);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  localparam logic [1:0] SOF_CODE = 2'b01;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] TA_DRIVE = 2'b10;

  typedef struct packed {
    logic [4:0] phy;
    logic [4:0] ra;
    logic [1:0] div_sel;
    logic       wr;
    logic       busy;
  } ctrl_t;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF0 = 10,
  parameter int HALF1 = 13,
  parameter int HALF2 = 21,
  parameter int HALF3 = 31
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       mdc,
  output logic       rise_stb,
  output logic       fall_stb
);

  localparam int HMAX01 = (HALF0 > HALF1) ? HALF0 : HALF1;
  localparam int HMAX23 = (HALF2 > HALF3) ? HALF2 : HALF3;
  localparam int HMAX   = (HMAX01 > HMAX23) ? HMAX01 : HMAX23;
  localparam int CW     = $clog2(HMAX + 1);

  logic [CW-1:0] cnt_q, cnt_nxt, term;
  logic          mdc_q, mdc_nxt, tick;

  always_comb begin
    case (sel)
      2'd0:    term = CW'(HALF0 - 1);
      2'd1:    term = CW'(HALF1 - 1);
      2'd2:    term = CW'(HALF2 - 1);
      default: term = CW'(HALF3 - 1);
    endcase
  end

  assign tick = run && (cnt_q == term);

  always_comb begin
    cnt_nxt = cnt_q;
    mdc_nxt = mdc_q;
    if (!run) begin
      cnt_nxt = '0;
      mdc_nxt = 1'b0;
    end else if (tick) begin
      cnt_nxt = '0;
      mdc_nxt = ~mdc_q;
    end else begin
      cnt_nxt = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      mdc_q <= mdc_nxt;
    end
  end

  assign mdc      = mdc_q;
  assign rise_stb = tick & ~mdc_q;
  assign fall_stb = tick &  mdc_q;

endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch,
  input  logic        wr,
  input  logic [4:0]  phy,
  input  logic [4:0]  ra,
  input  logic [15:0] wdata,
  input  logic        rise_stb,
  input  logic        fall_stb,
  input  logic        mdio_i,
  output logic        active,
  output logic        done,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] rdata
);

  logic                  act_q, act_nxt;
  logic [IDX_W-1:0]      idx_q, idx_nxt;
  logic [FRAME_BITS-1:0] sh_q, sh_nxt, frame;
  logic [15:0]           cap_q, cap_nxt;
  logic                  step_en, cap_en;

  assign frame = {{32{1'b1}}, SOF_CODE, (wr ? OP_WRITE : OP_READ), phy, ra, TA_DRIVE, wdata};

  assign step_en = act_q & fall_stb;
  assign done    = step_en & (idx_q == LAST_IDX);
  assign cap_en  = act_q & rise_stb & ~wr & (idx_q >= DATA_IDX);

  always_comb begin
    act_nxt = act_q;
    idx_nxt = idx_q;
    sh_nxt  = sh_q;
    if (launch) begin
      act_nxt = 1'b1;
      idx_nxt = '0;
      sh_nxt  = frame;
    end else if (done) begin
      act_nxt = 1'b0;
    end else if (step_en) begin
      idx_nxt = idx_q + 1'b1;
      sh_nxt  = {sh_q[FRAME_BITS-2:0], 1'b0};
    end
  end

  always_comb begin
    cap_nxt = cap_q;
    if (cap_en) cap_nxt = {cap_q[14:0], mdio_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
      sh_q  <= '0;
      cap_q <= '0;
    end else begin
      act_q <= act_nxt;
      idx_q <= idx_nxt;
      sh_q  <= sh_nxt;
      if (cap_en) cap_q <= cap_nxt;
    end
  end

  assign active  = act_q;
  assign mdio_o  = sh_q[FRAME_BITS-1];
  assign mdio_oe = act_q & (wr | (idx_q < TA_IDX));
  assign rdata   = cap_q;

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic        addr,
  input  logic [15:0] wdata,
  input  logic        done,
  input  logic [15:0] rdata,
  output ctrl_t       ctrl,
  output logic [15:0] data
);

  ctrl_t       ctrl_q, ctrl_nxt;
  logic [15:0] data_q, data_nxt;
  logic        ctrl_en, data_en;

  always_comb begin
    ctrl_nxt = ctrl_q;
    data_nxt = data_q;
    ctrl_en  = 1'b0;
    data_en  = 1'b0;
    if (done) begin
      ctrl_en       = 1'b1;
      ctrl_nxt.busy = 1'b0;
      if (!ctrl_q.wr) begin
        data_en  = 1'b1;
        data_nxt = rdata;
      end
    end else if (we && !ctrl_q.busy) begin
      if (addr) begin
        ctrl_en  = 1'b1;
        ctrl_nxt = ctrl_t'(wdata[13:0]);
      end else begin
        data_en  = 1'b1;
        data_nxt = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      data_q <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_nxt;
      if (data_en) data_q <= data_nxt;
    end
  end

  assign ctrl = ctrl_q;
  assign data = data_q;

endmodule

// File: rtl/mdio_station.sv
module mdio_station
  import mdio_pkg::*;
#(
  parameter int HALF0 = 10,
  parameter int HALF1 = 13,
  parameter int HALF2 = 21,
  parameter int HALF3 = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] data_q,
  output logic [13:0] ctrl_q,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);

  logic [1:0]  rst_pipe;
  logic        rst_s;
  ctrl_t       ctrl;
  logic        active, done, launch, rise_stb, fall_stb;
  logic [15:0] rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  assign launch = ctrl.busy & ~active;

  mdio_regs u_regs (
    .clk   (clk),
    .rst_n (rst_s),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .done  (done),
    .rdata (rdata),
    .ctrl  (ctrl),
    .data  (data_q)
  );

  mdio_clkgen #(
    .HALF0 (HALF0),
    .HALF1 (HALF1),
    .HALF2 (HALF2),
    .HALF3 (HALF3)
  ) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_s),
    .run      (active),
    .sel      (ctrl.div_sel),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_s),
    .launch   (launch),
    .wr       (ctrl.wr),
    .phy      (ctrl.phy),
    .ra       (ctrl.ra),
    .wdata    (data_q),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .active   (active),
    .done     (done),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rdata    (rdata)
  );

  assign ctrl_q = ctrl;

endmodule

// File: rtl/mdio_station_chk.sv
module mdio_station_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] data_q,
  input logic [13:0] ctrl_q,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);

  p_mdc_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |-> !mdc);

  p_oe_only_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> ctrl_q[0]);

  p_hold_while_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  p_ctrl_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && $past(ctrl_q[0])) |-> $stable(ctrl_q[13:1]));

  p_data_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && $past(ctrl_q[0])) |-> $stable(data_q));

endmodule

bind mdio_station mdio_station_chk i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .data_q  (data_q),
  .ctrl_q  (ctrl_q),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe)
);

// File: tb/test_mdio_station.sv
module test_mdio_station;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic        reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] data_q;
  logic [13:0] ctrl_q;
  logic        mdc, mdio_i, mdio_o, mdio_oe;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  localparam int HALF [4] = '{10, 13, 21, 31};

  // {phy[44:40], ra[39:35], sel[34:33], wr[32], wdata[31:16], rdret[15:0]}
  localparam logic [44:0] VEC [6] = '{
    {5'd0,  5'd13, 2'd0, 1'b1, 16'h1F00, 16'h0000},
    {5'd31, 5'd0,  2'd3, 1'b1, 16'hA5A5, 16'h0000},
    {5'd0,  5'd2,  2'd1, 1'b0, 16'h0000, 16'h2000},
    {5'd21, 5'd31, 2'd2, 1'b0, 16'h0000, 16'h8001},
    {5'd10, 5'd21, 2'd1, 1'b1, 16'h0000, 16'h0000},
    {5'd1,  5'd1,  2'd0, 1'b0, 16'h0000, 16'hFFFF}
  };

  mdio_station i_mdio_station (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .data_q    (data_q),
    .ctrl_q    (ctrl_q),
    .mdc       (mdc),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, 190000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic a, input logic [15:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic run_txn(input logic [44:0] v, input bit poke);
    logic [4:0]  phy  = v[44:40];
    logic [4:0]  ra   = v[39:35];
    logic [1:0]  sel  = v[34:33];
    logic        wr   = v[32];
    logic [15:0] wd   = v[31:16];
    logic [15:0] rr   = v[15:0];
    logic [63:0] got  = '0;
    logic [63:0] oeg  = '0;
    logic [63:0] exp;
    logic [63:0] oexp;
    logic [13:0] cw;
    logic        prev = 1'b0;
    int rises = 0, n = 0, t0 = 0, t1 = 0, pk = 0;
    cw = {phy, ra, sel, wr, 1'b1};
    if (wr) reg_write(1'b0, wd);
    reg_write(1'b1, {2'b00, cw});
    chk(ctrl_q == cw, "R2 ctrl readback with busy", 64'(ctrl_q), 64'(cw));
    while (ctrl_q[0] && n < 20000) begin
      @(negedge clk);
      n++;
      if (mdc && !prev) begin
        if (rises < 64) begin
          got[63-rises] = mdio_o;
          oeg[63-rises] = mdio_oe;
        end
        if (rises == 0) t0 = n;
        if (rises == 1) t1 = n;
        rises++;
      end
      prev = mdc;
      mdio_i = (rises >= 48 && rises < 64) ? rr[63-rises] : 1'b1;
      if (poke) begin
        if (pk == 0 && rises == 10) begin
          reg_we = 1'b1; reg_addr = 1'b1; reg_wdata = 16'h3FF0; pk = 1;
        end else if (pk == 1) begin
          reg_addr = 1'b0; reg_wdata = 16'hDEAD; pk = 2;
        end else if (pk == 2) begin
          reg_we = 1'b0; pk = 3;
        end
      end
    end
    chk(n < 20000 && ctrl_q[0] == 1'b0, "R2 busy clears", 64'(ctrl_q[0]), 64'(0));
    chk(rises == 64, "R3 MDC pulse count", 64'(rises), 64'(64));
    chk((t1 - t0) == 2 * HALF[sel], "R6 MDC period", 64'(t1 - t0), 64'(2 * HALF[sel]));
    if (wr) begin
      exp  = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, ra, 2'b10, wd};
      oexp = '1;
      chk(got == exp, "R3 write frame bits", got, exp);
      chk(oeg == oexp, "R3 write frame enable", oeg, oexp);
      chk(data_q == wd, "R9 data kept after write", 64'(data_q), 64'(wd));
    end else begin
      exp  = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, ra, 18'h0};
      oexp = {{46{1'b1}}, 18'h0};
      chk(got[63:18] == exp[63:18], "R4 read header bits", 64'(got[63:18]), 64'(exp[63:18]));
      chk(oeg == oexp, "R4 read release", oeg, oexp);
      chk(data_q == rr, "R5 read data capture", 64'(data_q), 64'(rr));
    end
    chk(ctrl_q[13:1] == cw[13:1], "R8 ctrl fields after frame", 64'(ctrl_q[13:1]), 64'(cw[13:1]));
  endtask

  initial begin
    reg_we = 1'b0; reg_addr = 1'b0; reg_wdata = '0; mdio_i = 1'b1;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(ctrl_q == '0, "R1 ctrl reset", 64'(ctrl_q), 64'(0));
    chk(data_q == '0, "R1 data reset", 64'(data_q), 64'(0));
    chk(!mdc && !mdio_oe, "R1 mdc/oe reset", 64'({mdc, mdio_oe}), 64'(0));

    foreach (VEC[i]) run_txn(VEC[i], 1'b0);

    // R8: writes in the middle of a frame are ignored
    run_txn({5'd7, 5'd9, 2'd0, 1'b1, 16'h5A3C, 16'h0000}, 1'b1);

    // R9: idle data write reads back
    reg_write(1'b0, 16'hBEEF);
    chk(data_q == 16'hBEEF, "R9 data readback", 64'(data_q), 64'hBEEF);

    // R2/R6: control word without busy is stored, no frame starts
    reg_write(1'b1, 16'h2AB6);
    chk(ctrl_q == 14'h2AB6, "R2 ctrl stored idle", 64'(ctrl_q), 64'h2AB6);
    begin
      bit moved = 1'b0;
      for (int k = 0; k < 80; k++) begin
        @(negedge clk);
        if (mdc || mdio_oe) moved = 1'b1;
      end
      chk(!moved, "R6 mdc idle without busy", 64'(moved), 64'(0));
    end
    chk(data_q == 16'hBEEF, "R2 data untouched without frame", 64'(data_q), 64'hBEEF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule